// File: doc/BRIEF.md
# Windowed Activity Power Estimator

This block turns per-cycle activity events into an estimate of dynamic energy for each scheduling window. Eight monitored sources (execution-unit inputs, register-file ports, bus lines) each report a small count of switching events every cycle. The block multiplies each source's count by a programmable weight and adds the weighted counts into a saturating accumulator. Over a window of programmable length, these sums form a window total.

At the last cycle of every window, the total is latched and compared with a programmed budget, and the accumulator restarts in the same cycle. The block then raises a one-cycle window-done pulse and updates three outputs: the latched total, the headroom left under the budget, and an over-budget flag with hysteresis. An issue throttle downstream uses these outputs to size the next window's activity.

Top module: `act_power_est`

## Requirements
- R1: While reset is asserted, and after its release until the first window ends, `win_done_o`, `over_budget_o`, `win_total_o` and `remaining_o` are all zero.
- R2: Each cycle the block adds the sum over units u of count_u × weight_u, where count_u is `evt_cnt_i[4u+3:4u]` (unsigned) and weight_u is `coef_i[8u+7:8u]` (unsigned).
- R3: The window length is `win_len_i`, clamped to a minimum of 16 and a maximum of 1024. `win_done_o` is a one-cycle pulse, and successive pulses are exactly one window length apart.
- R4: `win_total_o` equals the weighted sum of every cycle in the window just ended. The accumulator restarts at the boundary without dropping or double-counting a cycle.
- R5: The accumulator saturates at 2^20−1 instead of wrapping.
- R6: `remaining_o` is the budget minus the window total, or zero when the total is at or above the budget.
- R7: `over_budget_o` is set at a boundary whose total is strictly greater than the budget.
- R8: `over_budget_o` is cleared only at a boundary where 8×total < 7×budget. At any other boundary that is not over budget, it keeps its previous value.
- R9: The outputs change only with the done pulse. `budget_i` is sampled in the last cycle of the window, so changing it in mid-window has no visible effect until the boundary.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset, released synchronously inside |
| evt_cnt_i | input | 32 | Eight 4-bit per-cycle event counts, unit u at bits 4u+3:4u |
| coef_i | input | 64 | Eight 8-bit unit weights, unit u at bits 8u+7:8u |
| win_len_i | input | 11 | Requested window length in cycles (clamped 16..1024) |
| budget_i | input | 20 | Energy budget per window |
| win_done_o | output | 1 | One-cycle pulse after each window boundary |
| win_total_o | output | 20 | Latched weighted total of the last window |
| over_budget_o | output | 1 | Over-budget flag with hysteresis |
| remaining_o | output | 20 | Budget headroom left after the last window |

## Verification
All four results come from registers loaded at the clock edge that closes a window's last cycle. They therefore appear together with `win_done_o`, one edge after the last counted event. After reset release, two more edges pass through the reset synchronizer before the first window starts to count.

The bench drives inputs and samples outputs on the falling edge. It waits for the done pulse before comparing, and it changes stimulus on that same falling edge, so the next window sees the new inputs from its first cycle. While waiting, the bench confirms that the outputs stay frozen between pulses and measures the spacing between pulses to check the clamped window length.

// File: rtl/pae_pkg.sv
package pae_pkg;
  // Flag update chosen at a window boundary
  typedef enum logic [1:0] {
    HYS_HOLD  = 2'd0,
    HYS_SET   = 2'd1,
    HYS_CLEAR = 2'd2
  } hys_act_t;

  localparam int unsigned DEF_UNITS   = 8;
  localparam int unsigned DEF_CNT_W   = 4;
  localparam int unsigned DEF_COEF_W  = 8;
  localparam int unsigned DEF_ACC_W   = 20;
  localparam int unsigned DEF_MIN_WIN = 16;
  localparam int unsigned DEF_MAX_WIN = 1024;
endpackage

// File: rtl/pae_weight_sum.sv
module pae_weight_sum #(
  parameter int unsigned NUM_UNITS = 8,
  parameter int unsigned CNT_W     = 4,
  parameter int unsigned COEF_W    = 8,
  parameter int unsigned SUM_W     = CNT_W + COEF_W + $clog2(NUM_UNITS)
) (
  input  logic [NUM_UNITS*CNT_W-1:0]  evt_i,
  input  logic [NUM_UNITS*COEF_W-1:0] coef_i,
  output logic [SUM_W-1:0]            sum_o
);
  logic [SUM_W-1:0] prod [NUM_UNITS];

  for (genvar u = 0; u < NUM_UNITS; u++) begin : g_unit
    logic [CNT_W-1:0]  cnt;
    logic [COEF_W-1:0] wgt;
    assign cnt     = evt_i[u*CNT_W +: CNT_W];
    assign wgt     = coef_i[u*COEF_W +: COEF_W];
    assign prod[u] = SUM_W'(cnt) * SUM_W'(wgt);
  end

  always_comb begin
    sum_o = '0;
    for (int u = 0; u < NUM_UNITS; u++) begin
      sum_o = sum_o + prod[u];
    end
  end
endmodule

// File: rtl/pae_window_timer.sv
module pae_window_timer #(
  parameter int unsigned MIN_WIN = 16,
  parameter int unsigned MAX_WIN = 1024,
  parameter int unsigned LEN_W   = $clog2(MAX_WIN) + 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [LEN_W-1:0] win_len_i,
  output logic             last_o,
  output logic             done_o
);
  logic [LEN_W-1:0] eff_len;
  logic [LEN_W-1:0] cnt_q, cnt_d;
  logic             done_q, done_d;

  always_comb begin
    if (win_len_i < LEN_W'(MIN_WIN))      eff_len = LEN_W'(MIN_WIN);
    else if (win_len_i > LEN_W'(MAX_WIN)) eff_len = LEN_W'(MAX_WIN);
    else                                  eff_len = win_len_i;
  end

  // a shrinking length mid-window ends the window at once
  assign last_o = (cnt_q >= eff_len - LEN_W'(1));

  always_comb begin
    cnt_d  = last_o ? '0 : cnt_q + LEN_W'(1);
    done_d = last_o;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      done_q <= 1'b0;
    end else begin
      cnt_q  <= cnt_d;
      done_q <= done_d;
    end
  end

  assign done_o = done_q;

  // R3
  win_cnt_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q < LEN_W'(MAX_WIN));
  // R3
  done_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_q |=> !done_q);
endmodule

// File: rtl/pae_accum.sv
module pae_accum #(
  parameter int unsigned SUM_W = 15,
  parameter int unsigned ACC_W = 20
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [SUM_W-1:0] sum_i,
  input  logic             last_i,
  output logic [ACC_W-1:0] end_total_o,
  output logic [ACC_W-1:0] total_o
);
  logic [ACC_W-1:0] acc_q, acc_d;
  logic [ACC_W-1:0] total_q, total_d;
  logic [ACC_W:0]   ext;
  logic             total_en;

  assign ext         = {1'b0, acc_q} + (ACC_W + 1)'(sum_i);
  assign end_total_o = ext[ACC_W] ? {ACC_W{1'b1}} : ext[ACC_W-1:0];
  assign total_en    = last_i;

  always_comb begin
    acc_d   = last_i ? '0 : end_total_o;
    total_d = total_en ? end_total_o : total_q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      acc_q   <= '0;
      total_q <= '0;
    end else begin
      acc_q <= acc_d;
      if (total_en) total_q <= total_d;
    end
  end

  assign total_o = total_q;

  // R5
  no_wrap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !last_i |=> acc_q >= $past(acc_q));
endmodule

// File: rtl/pae_budget_cmp.sv
module pae_budget_cmp
  import pae_pkg::*;
#(
  parameter int unsigned ACC_W = 20
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [ACC_W-1:0] total_i,
  input  logic [ACC_W-1:0] budget_i,
  output logic             over_o,
  output logic [ACC_W-1:0] remain_o
);
  localparam int unsigned CMP_W = ACC_W + 3;

  logic             over_q, over_d;
  logic [ACC_W-1:0] rem_q, rem_d;
  logic             exceeds, below;
  logic [CMP_W-1:0] tot_x8, bud_x7;
  hys_act_t         act;

  assign exceeds = total_i > budget_i;
  assign tot_x8  = {total_i, 3'b000};
  assign bud_x7  = CMP_W'(budget_i) * CMP_W'(7);
  assign below   = tot_x8 < bud_x7;

  always_comb begin
    if (exceeds)    act = HYS_SET;
    else if (below) act = HYS_CLEAR;
    else            act = HYS_HOLD;
  end

  always_comb begin
    over_d = over_q;
    case (act)
      HYS_SET:   over_d = 1'b1;
      HYS_CLEAR: over_d = 1'b0;
      default:   over_d = over_q;
    endcase
    rem_d = (total_i >= budget_i) ? '0 : budget_i - total_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      over_q <= 1'b0;
      rem_q  <= '0;
    end else if (load_i) begin
      over_q <= over_d;
      rem_q  <= rem_d;
    end
  end

  assign over_o   = over_q;
  assign remain_o = rem_q;

  // R9
  hold_between_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !load_i |=> ($stable(over_q) && $stable(rem_q)));
  // R7
  over_set_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (load_i && (total_i > budget_i)) |=> (over_q && rem_q == '0));
  // R8
  over_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (load_i && over_q && (tot_x8 >= bud_x7)) |=> over_q);
endmodule

// File: rtl/act_power_est.sv
module act_power_est
  import pae_pkg::*;
#(
  parameter int unsigned NUM_UNITS = DEF_UNITS,
  parameter int unsigned CNT_W     = DEF_CNT_W,
  parameter int unsigned COEF_W    = DEF_COEF_W,
  parameter int unsigned ACC_W     = DEF_ACC_W,
  parameter int unsigned MIN_WIN   = DEF_MIN_WIN,
  parameter int unsigned MAX_WIN   = DEF_MAX_WIN,
  localparam int unsigned LEN_W    = $clog2(MAX_WIN) + 1,
  localparam int unsigned SUM_W    = CNT_W + COEF_W + $clog2(NUM_UNITS)
) (
  input  logic                        clk_i,
  input  logic                        rst_ni,
  input  logic [NUM_UNITS*CNT_W-1:0]  evt_cnt_i,
  input  logic [NUM_UNITS*COEF_W-1:0] coef_i,
  input  logic [LEN_W-1:0]            win_len_i,
  input  logic [ACC_W-1:0]            budget_i,
  output logic                        win_done_o,
  output logic [ACC_W-1:0]            win_total_o,
  output logic                        over_budget_o,
  output logic [ACC_W-1:0]            remaining_o
);
  logic             rst_meta_q, rst_sync_q;
  logic [SUM_W-1:0] cyc_sum;
  logic             win_last;
  logic [ACC_W-1:0] end_total;

  // assert asynchronously, release on the clock
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rst_meta_q <= 1'b0;
      rst_sync_q <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_sync_q <= rst_meta_q;
    end
  end

  pae_weight_sum #(
    .NUM_UNITS(NUM_UNITS), .CNT_W(CNT_W), .COEF_W(COEF_W), .SUM_W(SUM_W)
  ) u_wsum (
    .evt_i(evt_cnt_i), .coef_i(coef_i), .sum_o(cyc_sum)
  );

  pae_window_timer #(
    .MIN_WIN(MIN_WIN), .MAX_WIN(MAX_WIN), .LEN_W(LEN_W)
  ) u_timer (
    .clk_i(clk_i), .rst_ni(rst_sync_q), .win_len_i(win_len_i),
    .last_o(win_last), .done_o(win_done_o)
  );

  pae_accum #(
    .SUM_W(SUM_W), .ACC_W(ACC_W)
  ) u_accum (
    .clk_i(clk_i), .rst_ni(rst_sync_q), .sum_i(cyc_sum), .last_i(win_last),
    .end_total_o(end_total), .total_o(win_total_o)
  );

  pae_budget_cmp #(
    .ACC_W(ACC_W)
  ) u_cmp (
    .clk_i(clk_i), .rst_ni(rst_sync_q), .load_i(win_last),
    .total_i(end_total), .budget_i(budget_i),
    .over_o(over_budget_o), .remain_o(remaining_o)
  );

  // R6
  remain_bound_chk: assert property (@(posedge clk_i) disable iff (!rst_sync_q)
    win_last |=> (remaining_o <= $past(budget_i)));
  // R4
  total_with_done_chk: assert property (@(posedge clk_i) disable iff (!rst_sync_q)
    !win_done_o |=> $stable(win_total_o) || win_done_o);
endmodule

// File: tb/act_power_est_tb.sv
module act_power_est_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int NROWS = 12;
  localparam logic [63:0] COEF_RAMP = 64'h0807060504030201;

  localparam logic [31:0] T_EVT [NROWS] = '{
    32'h22222222, 32'h99999999, 32'h88888888, 32'h77777777,
    32'h88888888, 32'hF0000000, 32'h0000000F, 32'hFFFFFFFF,
    32'h00000000, 32'h11111111, 32'h11111111, 32'h11111111};
  localparam logic [19:0] T_BUD [NROWS] = '{
    20'd5000, 20'd5000, 20'd5000, 20'd5000, 20'd5000, 20'd5000,
    20'd5000, 20'd5000, 20'd0, 20'd600, 20'd700, 20'd576};
  localparam logic [19:0] T_TOT [NROWS] = '{
    20'd1152, 20'd5184, 20'd4608, 20'd4032, 20'd4608, 20'd1920,
    20'd240, 20'd8640, 20'd0, 20'd576, 20'd576, 20'd576};
  localparam logic T_FLG [NROWS] = '{
    1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0};
  localparam logic [19:0] T_REM [NROWS] = '{
    20'd3848, 20'd0, 20'd392, 20'd968, 20'd392, 20'd3080,
    20'd4760, 20'd0, 20'd0, 20'd24, 20'd124, 20'd0};

  logic        clk = 1'b0;
  logic        rst_n;
  logic [31:0] evt;
  logic [63:0] coef;
  logic [10:0] win_len;
  logic [19:0] budget;
  logic        done;
  logic [19:0] total;
  logic        over;
  logic [19:0] rem;

  int checks = 0;
  int fails  = 0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  act_power_est dut_i (
    .clk_i(clk), .rst_ni(rst_n), .evt_cnt_i(evt), .coef_i(coef),
    .win_len_i(win_len), .budget_i(budget), .win_done_o(done),
    .win_total_o(total), .over_budget_o(over), .remaining_o(rem)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // waits for the done pulse; returns spacing and whether outputs held still (R9)
  task automatic wait_done(output int n, output bit steady);
    logic [19:0] t0, r0;
    logic        f0;
    t0 = total; r0 = rem; f0 = over;
    n = 0; steady = 1'b1;
    do begin
      @(negedge clk);
      n++;
      if (!done && (total !== t0 || rem !== r0 || over !== f0)) steady = 1'b0;
    end while (!done && n < 3000);
    if (!done) begin
      checks++; fails++;
      $display("FAIL R3: actual no done pulse expected pulse within 3000 cycles");
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    int  n;
    bit  steady;
    rst_n = 1'b0; evt = T_EVT[0]; coef = COEF_RAMP; win_len = 11'd16; budget = T_BUD[0];
    repeat (3) @(negedge clk);
    // R1 during reset
    chk("R1 done", {31'd0, done}, 0);
    chk("R1 total", {12'd0, total}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 flag", {31'd0, over}, 0);
    chk("R1 remain", {12'd0, rem}, 0);

    // table walk: R2 R4 R6 R7 R8
    for (int i = 0; i < NROWS; i++) begin
      wait_done(n, steady);
      chk("R4 total", {12'd0, total}, {12'd0, T_TOT[i]});
      chk("R7/R8 flag", {31'd0, over}, {31'd0, T_FLG[i]});
      chk("R6 remain", {12'd0, rem}, {12'd0, T_REM[i]});
      chk("R9 steady", {31'd0, steady}, 1);
      if (i > 0) chk("R3 period", n, 16);
      if (i + 1 < NROWS) begin
        evt = T_EVT[i + 1]; budget = T_BUD[i + 1];
      end
    end
    @(negedge clk);
    chk("R3 pulse width", {31'd0, done}, 0);
    // previous window already started; set saturation stimulus at next boundary
    wait_done(n, steady);

    // R5 saturation, 64-cycle window
    evt = 32'hFFFFFFFF; coef = {8{8'hFF}}; budget = 20'd1000; win_len = 11'd64;
    wait_done(n, steady);
    chk("R3 period 64", n, 64);
    chk("R5 saturate", {12'd0, total}, 32'hFFFFF);
    chk("R7 flag", {31'd0, over}, 1);
    chk("R6 remain", {12'd0, rem}, 0);

    // R3 low clamp, idle window clears flag
    evt = 32'h0; win_len = 11'd5;
    wait_done(n, steady);
    chk("R3 clamp low", n, 16);
    chk("R8 clear", {31'd0, over}, 0);
    chk("R6 remain", {12'd0, rem}, 1000);

    // R3 high clamp
    win_len = 11'd2000;
    wait_done(n, steady);
    chk("R3 clamp high", n, 1024);

    // R9 budget change mid-window
    coef = COEF_RAMP; evt = 32'h11111111; win_len = 11'd16; budget = 20'd700;
    repeat (5) @(negedge clk);
    budget = 20'd100;
    @(negedge clk);
    chk("R9 no early effect", {12'd0, rem}, 1000);
    chk("R9 flag held", {31'd0, over}, 0);
    wait_done(n, steady);
    chk("R9 late budget used", {31'd0, over}, 1);
    chk("R6 remain", {12'd0, rem}, 0);

    // R1 reset mid-run
    rst_n = 1'b0;
    @(negedge clk);
    chk("R1 flag after reset", {31'd0, over}, 0);
    chk("R1 total after reset", {12'd0, total}, 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule